// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line. Each frame is a low start bit, then the data bits least-significant first, then an optional extra bit, then one or two high stop bits. The extra bit is either a parity bit or an address-marker bit taken from a dedicated input. Five mode inputs choose the character length (7 or 8 bits), parity on or off, even or odd parity, marker bit instead of parity, and the stop-bit count. Together they give twelve distinct frame layouts.

Characters enter through a valid/ready stream port. `in_ready` is high only while the transmitter is idle, and a character is taken on a clock edge where both `in_valid` and `in_ready` are high. A source that holds `in_valid` with `in_ready` low keeps its data and mode steady until the transfer happens. Nothing is dropped and nothing is buffered. The mode inputs and the marker input are captured with the character, so they may change freely while a frame is on the line. Bit timing comes from `bit_tick`, a one-cycle pulse at sixteen times the bit rate. It may come from an internal divider or from a synchronised external clock. A bit lasts `OVERSAMPLE` ticks.

An optional clock output runs at the bit rate. It is low for the first half of each bit and high for the second half, so its rising edge falls at the middle of every transmitted bit. It rests high when no frame is on the line.

Top module: `async_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_line` is 1 and `in_ready` is 1. While a frame is in progress, `in_ready` is 0.
- R2: On the clock edge that accepts a character, a start bit (`tx_line` = 0) begins. Every bit of the frame lasts exactly `OVERSAMPLE` (default 16) `bit_tick` pulses.
- R3: Data bits follow the start bit least-significant bit first: 8 bits when `cfg_char7` = 0, and 7 bits when `cfg_char7` = 1. In 7-bit mode, bit 7 of `in_data` is never sent.
- R4: When `cfg_mp_en` = 0 and `cfg_par_en` = 1, a parity bit follows the data bits. It is computed over the sent data bits only: with `cfg_par_odd` = 0 it makes the count of ones even, and with `cfg_par_odd` = 1 it makes the count odd. When `cfg_par_en` = 0 and `cfg_mp_en` = 0, there is no extra bit.
- R5: When `cfg_mp_en` = 1, the value of `in_mpbit` is sent after the data bits in place of parity, and `cfg_par_en` has no effect.
- R6: The frame ends with one stop bit (`cfg_stop2` = 0) or two stop bits (`cfg_stop2` = 1), each at level 1.
- R7: `in_data`, `in_mpbit` and all `cfg_*` mode inputs are captured at acceptance. Changing them during a frame does not alter that frame.
- R8: When `cfg_clk_out_en` = 1, `clk_out` is 0 during ticks 0 to `OVERSAMPLE`/2-1 of each bit and 1 during the rest, so it rises at mid-bit. It is 1 when idle. When `cfg_clk_out_en` = 0, `clk_out` is 0.
- R9: When `in_valid` is held high, the next start bit begins exactly one clock cycle after the last stop bit ends.
- R10: Without `bit_tick` pulses the frame does not advance: the current bit level and `in_ready` = 0 are held until ticks resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter idle, character will be taken |
| in_data | input | DATA_W | Character to send, bit 0 first |
| in_mpbit | input | 1 | Marker bit value used when cfg_mp_en = 1 |
| cfg_char7 | input | 1 | 1: 7-bit character, 0: 8-bit |
| cfg_par_en | input | 1 | 1: send parity bit (when cfg_mp_en = 0) |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_mp_en | input | 1 | 1: send marker bit instead of parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_clk_out_en | input | 1 | 1: drive bit-rate clock on clk_out |
| tx_line | output | 1 | Serial output, idles high |
| clk_out | output | 1 | Bit-rate clock, rising at mid-bit |

## Verification
Two things can happen in the same clock cycle: the end of the last stop bit and the acceptance of the next character. The bench provokes this by holding `in_valid` high through a whole frame. It then checks that the line is high in the cycle after the last stop bit and low with a new start bit in the cycle after that. The bench also changes every mode input and the character in the cycle right after acceptance, and checks that each captured frame still matches the mode given at acceptance.

// File: rtl/aft_pkg.sv
package aft_pkg;

  typedef struct packed {
    logic char7;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic stop2;
  } frame_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_EXTRA = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } tx_state_t;

endpackage

// File: rtl/aft_bit_timer.sv
module aft_bit_timer #(
  parameter int OVERSAMPLE = 16,
  localparam int PW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [PW-1:0] phase,
  output logic          bit_end
);

  localparam logic [PW-1:0] LAST = PW'(OVERSAMPLE - 1);

  assign bit_end = run && tick && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= '0;
    end else if (tick) begin
      phase <= bit_end ? '0 : phase + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase) < OVERSAMPLE); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (phase == $past(phase))); // R10

endmodule

// File: rtl/aft_frame_seq.sv
module aft_frame_seq
  import aft_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  logic              mpbit,
  input  frame_mode_t       mode,
  input  logic              bit_end,
  output logic              busy,
  output logic              line
);

  localparam logic [CW-1:0] FULL_LAST  = CW'(DATA_W - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(DATA_W - 2);

  tx_state_t         state;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     bits_left;
  logic              extra_en_q;
  logic              extra_val_q;
  logic              stop2_q;

  logic [DATA_W-1:0] masked;
  logic              parity;

  always_comb begin
    masked = data;
    if (mode.char7) masked[DATA_W-1] = 1'b0;
    parity = (^masked) ^ mode.par_odd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bits_left   <= '0;
      extra_en_q  <= 1'b0;
      extra_val_q <= 1'b0;
      stop2_q     <= 1'b0;
    end else if (accept && state == ST_IDLE) begin
      state       <= ST_START;
      shreg       <= data;
      bits_left   <= mode.char7 ? SHORT_LAST : FULL_LAST;
      extra_en_q  <= mode.mp_en | mode.par_en;
      extra_val_q <= mode.mp_en ? mpbit : parity;
      stop2_q     <= mode.stop2;
    end else if (bit_end) begin
      unique case (state)
        ST_START: state <= ST_DATA;
        ST_DATA: begin
          shreg <= shreg >> 1;
          if (bits_left == '0) begin
            state <= extra_en_q ? ST_EXTRA : ST_STOP1;
          end else begin
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_EXTRA: state <= ST_STOP1;
        ST_STOP1: state <= stop2_q ? ST_STOP2 : ST_IDLE;
        ST_STOP2: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_EXTRA: line = extra_val_q;
      default:  line = 1'b1;
    endcase
  end

  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !busy) |=> (state == ST_START && !line)); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line); // R1

  AST_EXTRA_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXTRA) |-> extra_en_q); // R4

  AST_SECOND_STOP_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP2) |-> stop2_q); // R6

endmodule

// File: rtl/aft_clk_phaser.sv
module aft_clk_phaser #(
  parameter int OVERSAMPLE = 16,
  localparam int PW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          busy,
  input  logic [PW-1:0] phase,
  output logic          clk_out
);

  localparam logic [PW-1:0] HALF = PW'(OVERSAMPLE / 2);

  assign clk_out = enable && (!busy || (phase >= HALF));

  AST_CLK_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |-> !clk_out); // R8

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import aft_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int PW   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1,
  localparam int HALF = OVERSAMPLE / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mpbit,
  input  logic              cfg_char7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mp_en,
  input  logic              cfg_stop2,
  input  logic              cfg_clk_out_en,
  output logic              tx_line,
  output logic              clk_out
);

  frame_mode_t   mode;
  logic          busy;
  logic          accept;
  logic [PW-1:0] phase;
  logic          bit_end;

  assign mode     = '{char7: cfg_char7, par_en: cfg_par_en, par_odd: cfg_par_odd,
                      mp_en: cfg_mp_en, stop2: cfg_stop2};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  aft_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .tick    (bit_tick),
    .phase   (phase),
    .bit_end (bit_end)
  );

  aft_frame_seq #(.DATA_W(DATA_W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .data    (in_data),
    .mpbit   (in_mpbit),
    .mode    (mode),
    .bit_end (bit_end),
    .busy    (busy),
    .line    (tx_line)
  );

  aft_clk_phaser #(.OVERSAMPLE(OVERSAMPLE)) phaser_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cfg_clk_out_en),
    .busy    (busy),
    .phase   (phase),
    .clk_out (clk_out)
  );

  AST_CLK_RISE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_out) && busy && $past(busy) && $past(cfg_clk_out_en))
      |-> (32'(phase) == HALF)); // R8

  AST_FRAME_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_line)); // R6

  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> !in_ready); // R1

endmodule

// File: tb/async_frame_tx_tb_top.sv
module async_frame_tx_tb_top;

  localparam int OS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick;
  logic       tick_en = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_mpbit = 1'b0;
  logic       cfg_char7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_mp_en = 1'b0, cfg_stop2 = 1'b0, cfg_clk_out_en = 1'b1;
  logic       tx_line, clk_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;
  assign bit_tick = tick_en;

  async_frame_tx #(.DATA_W(8), .OVERSAMPLE(OS)) dut_i (
    .clk, .rst_n, .bit_tick, .in_valid, .in_ready, .in_data, .in_mpbit,
    .cfg_char7, .cfg_par_en, .cfg_par_odd, .cfg_mp_en, .cfg_stop2,
    .cfg_clk_out_en, .tx_line, .clk_out
  );

  // {data, char7, par_en, par_odd, mp_en, stop2, mpbit, frame length}
  localparam logic [17:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10},
    {8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd12},
    {8'h81, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10},
    {8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd11},
    {8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd11},
    {8'h96, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd11},
    {8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd11}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected frame, element 0 is the start bit, built from the requirements.
  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic c7,
      input logic pe, input logic po, input logic mp, input logic mpb);
    logic [11:0] f;
    int k;
    int nd;
    logic ones;
    f = '1;
    f[0] = 1'b0;
    nd = c7 ? 7 : 8;
    ones = 1'b0;
    k = 1;
    for (int i = 0; i < nd; i++) begin
      f[k] = d[i];
      ones ^= d[i];
      k++;
    end
    if (mp) begin
      f[k] = mpb;
    end else if (pe) begin
      f[k] = po ? ~ones : ones;
    end
    return f;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic run_frame(input logic [17:0] v, input logic ck_en);
    logic [11:0] cap, exp;
    logic        clk_bad;
    int          len;
    len = int'(v[3:0]);
    wait_idle();
    in_data = v[17:10];
    {cfg_char7, cfg_par_en, cfg_par_odd, cfg_mp_en, cfg_stop2, in_mpbit} = v[9:4];
    cfg_clk_out_en = ck_en;
    in_valid = 1'b1;
    @(posedge clk);
    cap = '1;
    clk_bad = 1'b0;
    for (int j = 0; j < OS * len; j++) begin
      @(negedge clk);
      if (j == 0) begin
        // R7: change everything just after acceptance
        in_valid = 1'b0;
        in_data = ~in_data;
        {cfg_char7, cfg_par_en, cfg_par_odd, cfg_mp_en, cfg_stop2, in_mpbit} = ~v[9:4];
      end
      if (j % OS == OS / 2) cap[j / OS] = tx_line;
      if (j % OS == OS / 4 && clk_out !== 1'b0) clk_bad = 1'b1;
      if (j % OS == 3 * OS / 4 && clk_out !== ck_en) clk_bad = 1'b1;
      if (j == OS * len - 1 && in_ready !== 1'b0) clk_bad = 1'b1;
    end
    exp = exp_frame(v[17:10], v[9], v[8], v[7], v[6], v[4]);
    for (int i = len; i < 12; i++) exp[i] = 1'b1;
    check(cap === exp, "R2/R3/R4/R5/R6/R7", "frame bits", 32'(cap), 32'(exp));
    check(!clk_bad, "R8", "clock phase / busy", 32'(clk_bad), 32'd0);
    @(negedge clk);
    check(in_ready === 1'b1 && tx_line === 1'b1, "R1/R6", "idle after frame",
          {in_ready, tx_line}, 32'h3);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_line === 1'b1 && in_ready === 1'b1, "R1", "reset idle",
          {in_ready, tx_line}, 32'h3);
    check(clk_out === 1'b1, "R8", "idle clock high", 32'(clk_out), 32'd1);
    cfg_clk_out_en = 1'b0;
    @(negedge clk);
    check(clk_out === 1'b0, "R8", "clock disabled", 32'(clk_out), 32'd0);

    // Table walk
    for (int t = 0; t < 8; t++) run_frame(VEC[t], (t % 4) != 3);

    // R10: stalled tick holds the start bit
    tick_en = 1'b0;
    wait_idle();
    in_data = 8'h5A;
    {cfg_char7, cfg_par_en, cfg_par_odd, cfg_mp_en, cfg_stop2} = '0;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (100) @(negedge clk);
    check(tx_line === 1'b0 && in_ready === 1'b0, "R10", "hold without tick",
          {in_ready, tx_line}, 32'h0);
    tick_en = 1'b1;
    repeat (OS * 10 - 2) @(negedge clk);
    check(in_ready === 1'b0, "R10", "still busy near end", 32'(in_ready), 32'd0);
    repeat (4) @(negedge clk);
    check(in_ready === 1'b1, "R10", "done after resume", 32'(in_ready), 32'd1);

    // R9: back-to-back with valid held
    wait_idle();
    in_data = 8'hC3;
    {cfg_char7, cfg_par_en, cfg_par_odd, cfg_mp_en, cfg_stop2} = '0;
    in_valid = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= OS * 10 + 1; j++) begin
      @(negedge clk);
      if (j == 0) in_data = 8'h3C;
      if (j == OS * 10)
        check(tx_line === 1'b1, "R9", "gap cycle high", 32'(tx_line), 32'd1);
      if (j == OS * 10 + 1) begin
        check(tx_line === 1'b0 && in_ready === 1'b0, "R9", "second start bit",
              {in_ready, tx_line}, 32'h0);
        in_valid = 1'b0;
      end
    end
    wait_idle();
    check(tx_line === 1'b1, "R9", "second frame ends high", 32'(tx_line), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule